// File: doc/BRIEF.md
# Carrier Detect and Half-Duplex Direction Controller

This block sits between the receive front end of a frequency-shift-keyed line modem and its digital interface. It decides whether a usable receive carrier is present and steers the half-duplex direction of the modem. A per-sample flag from the front end says the filtered line signal exceeds the detection amplitude, and a bit-rate strobe marks each bit time (1/1200 s at the usual line rate). The block qualifies that flag over whole bit times before it raises or drops the carrier-detect output. The qualification is asymmetric in time: one window applies for acquiring the carrier, another for losing it, and a separate blanking window applies after the modem turns around from sending to listening.

The active-low request-to-send input chooses the direction. Low means transmit: carrier detect is forced low, the received-data line is parked at its idle-high level, and a transmit-enable output goes high. When request-to-send rises, the controller ignores the carrier flag for a fixed number of bit times so that echo of its own transmission cannot be taken for a remote carrier. It then runs the normal acquisition. The received-data output carries the demodulated bit stream only while carrier detect is high.

Top module: `cd_duplex_ctrl`

## Requirements
- R1: After reset, cd is 0, rxd is 1 and tx_en is 0, and the block is in receive mode with no carrier.
- R2: In receive mode, cd rises on the clock edge of the ON_BITS-th consecutive bit_tick with carrier_above at 1 (default 4).
- R3: A single bit_tick with carrier_above at 0 during acquisition restarts the count, so ON_BITS further set ticks are needed.
- R4: While cd is high, it falls on the clock edge of the OFF_BITS-th consecutive bit_tick with carrier_above at 0 (default 4).
- R5: A single bit_tick with carrier_above at 1 during loss qualification keeps cd high and restarts the loss count.
- R6: Once rts_n is low, tx_en goes to 1 within SYNC_STAGES+1 clocks, from any state. While it stays low, cd is 0 and rxd is 1 whatever carrier_above, rx_demod and bit_tick do.
- R7: After rts_n returns high, carrier_above is ignored for TURN_BITS bit ticks, and acquisition per R2 follows. With a constant carrier, cd rises on tick TURN_BITS+ON_BITS (default 8, no later than the 10 bit times allowed).
- R8: rxd equals rx_demod while cd is 1 and is held at 1 while cd is 0.
- R9: Without bit_tick, carrier_above has no effect: cd keeps its value for any number of clocks in receive mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_tick | input | 1 | One-clock strobe once per bit time |
| carrier_above | input | 1 | Front-end flag: receive amplitude above detection level |
| rts_n | input | 1 | Active-low request to send; low selects transmit |
| rx_demod | input | 1 | Demodulated receive bit from the discriminator |
| cd | output | 1 | Carrier detect, high while a qualified carrier is present |
| rxd | output | 1 | Gated receive data, idle high unless cd is high |
| tx_en | output | 1 | High while the modem is in transmit mode |

## Verification
The assertions assume that bit_tick is a single-clock strobe with idle clocks between strobes. They also assume that carrier_above is meaningful only on tick clocks, and that rts_n may change at any clock because it passes through the synchronizer first. The stimulus drives every input on the falling clock edge and pulses bit_tick for exactly one clock, with idle clocks around it. It holds rts_n steady for several clocks around each change, so each transition of the mode machine is triggered by one known cause. The carrier flag is also held steady across stretches with no tick, so any change of cd in those stretches would show up as a violation of R9.

// File: rtl/cdd_pkg.sv
package cdd_pkg;
   typedef enum logic [2:0] {
      ST_IDLE     = 3'd0,
      ST_QUAL_ON  = 3'd1,
      ST_DETECTED = 3'd2,
      ST_QUAL_OFF = 3'd3,
      ST_TX       = 3'd4,
      ST_TURN     = 3'd5
   } cdd_state_e;
endpackage

// File: rtl/cdd_rts_sync.sv
module cdd_rts_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic rts_n_in,
   output logic tx_req
);
   generate
      if (STAGES < 0) begin : g_bad
         $error("cdd_rts_sync: STAGES must not be negative");
      end
      if (STAGES == 0) begin : g_direct
         assign tx_req = ~rts_n_in;
      end else begin : g_chain
         logic [STAGES-1:0] chain_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q <= '1;
            else if (STAGES == 1) chain_q[0] <= rts_n_in;
            else chain_q <= {chain_q[STAGES-2:0], rts_n_in};
         end
         assign tx_req = ~chain_q[STAGES-1];
      end
   endgenerate
endmodule

// File: rtl/cdd_bit_counter.sv
module cdd_bit_counter #(
   parameter int CNT_W     = 3,
   parameter int CNT_LIMIT = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             inc,
   output logic [CNT_W-1:0] count
);
   localparam logic [CNT_W-1:0] LIMIT_V = CNT_W'(CNT_LIMIT);

   generate
      if ((1 << CNT_W) <= CNT_LIMIT) begin : g_bad_width
         $error("cdd_bit_counter: CNT_W too narrow for CNT_LIMIT");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) count <= '0;
      else if (clr || inc) count <= (clr ? '0 : count) + CNT_W'(inc);
   end

   // R3
   no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      count <= LIMIT_V);
endmodule

// File: rtl/cdd_fsm.sv
module cdd_fsm
   import cdd_pkg::*;
#(
   parameter int ON_BITS   = 4,
   parameter int OFF_BITS  = 4,
   parameter int TURN_BITS = 4,
   parameter int CNT_W     = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             bit_tick,
   input  logic             carrier_above,
   input  logic             tx_req,
   input  logic [CNT_W-1:0] cnt,
   output logic             cnt_clr,
   output logic             cnt_inc,
   output cdd_state_e       state
);
   localparam logic [CNT_W-1:0] ON_LAST   = CNT_W'(ON_BITS - 1);
   localparam logic [CNT_W-1:0] OFF_LAST  = CNT_W'(OFF_BITS - 1);
   localparam logic [CNT_W-1:0] TURN_LAST = CNT_W'(TURN_BITS - 1);
   localparam bit ON_SINGLE  = (ON_BITS == 1);
   localparam bit OFF_SINGLE = (OFF_BITS == 1);

   cdd_state_e state_nxt;

   always_comb begin
      state_nxt = state;
      cnt_clr   = 1'b0;
      cnt_inc   = 1'b0;
      if (tx_req && state != ST_TX) begin
         state_nxt = ST_TX;
         cnt_clr   = 1'b1;
      end else begin
         case (state)
            ST_TX: begin
               if (!tx_req) begin
                  state_nxt = ST_TURN;
                  cnt_clr   = 1'b1;
               end
            end
            ST_TURN: begin
               if (bit_tick) begin
                  if (cnt == TURN_LAST) begin
                     state_nxt = ST_IDLE;
                     cnt_clr   = 1'b1;
                  end else begin
                     cnt_inc = 1'b1;
                  end
               end
            end
            ST_IDLE: begin
               if (bit_tick && carrier_above) begin
                  cnt_clr = 1'b1;
                  if (ON_SINGLE) state_nxt = ST_DETECTED;
                  else begin
                     state_nxt = ST_QUAL_ON;
                     cnt_inc   = 1'b1;
                  end
               end
            end
            ST_QUAL_ON: begin
               if (bit_tick) begin
                  if (!carrier_above) begin
                     state_nxt = ST_IDLE;
                     cnt_clr   = 1'b1;
                  end else if (cnt == ON_LAST) begin
                     state_nxt = ST_DETECTED;
                     cnt_clr   = 1'b1;
                  end else begin
                     cnt_inc = 1'b1;
                  end
               end
            end
            ST_DETECTED: begin
               if (bit_tick && !carrier_above) begin
                  cnt_clr = 1'b1;
                  if (OFF_SINGLE) state_nxt = ST_IDLE;
                  else begin
                     state_nxt = ST_QUAL_OFF;
                     cnt_inc   = 1'b1;
                  end
               end
            end
            ST_QUAL_OFF: begin
               if (bit_tick) begin
                  if (carrier_above) begin
                     state_nxt = ST_DETECTED;
                     cnt_clr   = 1'b1;
                  end else if (cnt == OFF_LAST) begin
                     state_nxt = ST_IDLE;
                     cnt_clr   = 1'b1;
                  end else begin
                     cnt_inc = 1'b1;
                  end
               end
            end
            default: begin
               state_nxt = ST_IDLE;
               cnt_clr   = 1'b1;
            end
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state <= ST_IDLE;
      else state <= state_nxt;
   end

   // R9
   no_tick_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!bit_tick && !tx_req && state != ST_TX) |=> $stable(state));

   // R7
   turn_from_tx_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_TURN && $past(state) != ST_TURN) |-> $past(state) == ST_TX);

   // R6
   tx_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tx_req |=> state == ST_TX);
endmodule

// File: rtl/cd_duplex_ctrl.sv
module cd_duplex_ctrl
   import cdd_pkg::*;
#(
   parameter int ON_BITS     = 4,
   parameter int OFF_BITS    = 4,
   parameter int TURN_BITS   = 4,
   parameter int TURN_LIMIT  = 10,
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic bit_tick,
   input  logic carrier_above,
   input  logic rts_n,
   input  logic rx_demod,
   output logic cd,
   output logic rxd,
   output logic tx_en
);
   localparam int MAX_A     = (ON_BITS > OFF_BITS) ? ON_BITS : OFF_BITS;
   localparam int MAX_BITS  = (MAX_A > TURN_BITS) ? MAX_A : TURN_BITS;
   localparam int CNT_W     = $clog2(MAX_BITS + 1);

   generate
      if (ON_BITS < 1 || OFF_BITS < 1 || TURN_BITS < 1) begin : g_bad_bits
         $error("cd_duplex_ctrl: bit-time windows must be at least 1");
      end
      if (TURN_BITS + ON_BITS > TURN_LIMIT) begin : g_bad_turn
         $error("cd_duplex_ctrl: turnaround plus acquisition exceeds limit");
      end
   endgenerate

   logic             tx_req;
   logic             cnt_clr;
   logic             cnt_inc;
   logic [CNT_W-1:0] cnt;
   cdd_state_e       state;

   cdd_rts_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk      (clk),
      .rst_n    (rst_n),
      .rts_n_in (rts_n),
      .tx_req   (tx_req)
   );

   cdd_bit_counter #(.CNT_W(CNT_W), .CNT_LIMIT(MAX_BITS)) u_cnt (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (cnt_clr),
      .inc   (cnt_inc),
      .count (cnt)
   );

   cdd_fsm #(
      .ON_BITS   (ON_BITS),
      .OFF_BITS  (OFF_BITS),
      .TURN_BITS (TURN_BITS),
      .CNT_W     (CNT_W)
   ) u_fsm (
      .clk           (clk),
      .rst_n         (rst_n),
      .bit_tick      (bit_tick),
      .carrier_above (carrier_above),
      .tx_req        (tx_req),
      .cnt           (cnt),
      .cnt_clr       (cnt_clr),
      .cnt_inc       (cnt_inc),
      .state         (state)
   );

   assign cd    = (state == ST_DETECTED) || (state == ST_QUAL_OFF);
   assign tx_en = (state == ST_TX);
   assign rxd   = cd ? rx_demod : 1'b1;

   // R8
   rxd_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !cd |-> rxd);

   // R6
   tx_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tx_en |-> (!cd && rxd));

   // R2
   cd_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cd) |-> ($past(bit_tick) && $past(carrier_above)));

   // R4
   cd_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(cd) |-> (($past(bit_tick) && !$past(carrier_above)) || $past(tx_req)));
endmodule

// File: tb/cd_duplex_ctrl_test.sv
module cd_duplex_ctrl_test;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic bit_tick = 1'b0;
   logic carrier_above = 1'b0;
   logic rts_n = 1'b1;
   logic rx_demod = 1'b0;
   logic cd, rxd, tx_en;

   int tests = 0;
   int fails = 0;
   bit done = 1'b0;

   // Each entry {carrier flag for the tick, expected cd after the tick}
   localparam logic [1:0] VEC [0:21] = '{
      2'b10, 2'b10, 2'b10, 2'b11,
      2'b01, 2'b01, 2'b01, 2'b00,
      2'b10, 2'b10, 2'b00, 2'b10, 2'b10, 2'b10, 2'b11,
      2'b01, 2'b01, 2'b11, 2'b01, 2'b01, 2'b01, 2'b00
   };

   always #5 clk = ~clk;

   cd_duplex_ctrl uut (
      .clk           (clk),
      .rst_n         (rst_n),
      .bit_tick      (bit_tick),
      .carrier_above (carrier_above),
      .rts_n         (rts_n),
      .rx_demod      (rx_demod),
      .cd            (cd),
      .rxd           (rxd),
      .tx_en         (tx_en)
   );

   task automatic chk(input logic act, input logic exp, input string req);
      tests++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: got %b expected %b", req, act, exp);
      end
   endtask

   task automatic tick(input logic flag);
      @(negedge clk);
      carrier_above = flag;
      bit_tick = 1'b1;
      @(negedge clk);
      bit_tick = 1'b0;
      @(negedge clk);
   endtask

   task automatic idle(input int n);
      for (int k = 0; k < n; k++) @(negedge clk);
   endtask

   initial begin : watchdog
      for (int c = 0; c < 200000; c++) begin
         @(posedge clk);
         if (done) disable watchdog;
      end
      fails++;
      tests++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      idle(3);
      // R1 reset state
      chk(cd, 1'b0, "R1 cd");
      chk(rxd, 1'b1, "R1 rxd");
      chk(tx_en, 1'b0, "R1 tx_en");
      rst_n = 1'b1;
      idle(2);

      // R2 R3 R4 R5 vector walk, with R8 gating per step
      for (int i = 0; i < 22; i++) begin
         string tag;
         tag = (i < 4) ? "R2" : (i < 8) ? "R4" : (i < 15) ? "R3" : "R5";
         rx_demod = 1'b0;
         tick(VEC[i][1]);
         chk(cd, VEC[i][0], tag);
         chk(rxd, ~VEC[i][0], "R8 gate low");
      end

      // R8 pass-through of a 1 while detected
      for (int i = 0; i < 4; i++) tick(1'b1);
      rx_demod = 1'b1;
      idle(1);
      chk(rxd, 1'b1, "R8 pass one");
      rx_demod = 1'b0;
      idle(1);
      chk(rxd, 1'b0, "R8 pass zero");

      // R9 no tick, carrier flag flips: cd held
      carrier_above = 1'b0;
      idle(20);
      chk(cd, 1'b1, "R9 hold high");

      // R6 transmit entry from detected state
      rts_n = 1'b0;
      idle(4);
      chk(tx_en, 1'b1, "R6 tx_en");
      chk(cd, 1'b0, "R6 cd forced");
      chk(rxd, 1'b1, "R6 rxd idle");
      for (int i = 0; i < 6; i++) tick(1'b1);
      rx_demod = 1'b0;
      idle(1);
      chk(cd, 1'b0, "R6 cd during tx ticks");
      chk(rxd, 1'b1, "R6 rxd during tx ticks");

      // R7 turnaround with steady carrier
      rts_n = 1'b1;
      idle(4);
      chk(tx_en, 1'b0, "R7 tx_en released");
      for (int i = 0; i < 7; i++) tick(1'b1);
      chk(cd, 1'b0, "R7 cd after 7 ticks");
      tick(1'b1);
      chk(cd, 1'b1, "R7 cd after 8 ticks");

      // R9 no tick in idle with flag set
      for (int i = 0; i < 4; i++) tick(1'b0);
      chk(cd, 1'b0, "R4 dropped");
      carrier_above = 1'b1;
      idle(20);
      chk(cd, 1'b0, "R9 hold low");

      // R6 transmit request during acquisition, then clear ticks in turnaround
      tick(1'b1);
      tick(1'b1);
      rts_n = 1'b0;
      idle(4);
      chk(tx_en, 1'b1, "R6 tx from acquisition");
      rts_n = 1'b1;
      idle(4);
      for (int i = 0; i < 4; i++) tick(1'b0);
      for (int i = 0; i < 3; i++) tick(1'b1);
      chk(cd, 1'b0, "R7 three after blanking");
      tick(1'b1);
      chk(cd, 1'b1, "R7 four after blanking");

      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule